// File: doc/BRIEF.md
# GPIO Pin Event Detector

This block watches the 32 input pins of a general-purpose port and turns pin activity into per-pin events. Each pin carries a 4-bit mode that picks what counts as an event (a rising edge, a falling edge, either edge, a low level or a high level) and what the event does. It can set a status flag only, set a flag and request a DMA transfer, set a flag and raise an interrupt, or drive a trigger output directly from the pin level. A per-pin channel bit routes the interrupt, DMA request or trigger to one of two outputs.

Flags are sticky. Software clears them by writing ones, either across all pins or only on the pins routed to one channel. A flag that belongs to a DMA mode also clears when the DMA engine reports that the transfer for that channel is done. A level-mode flag sets again right after a clear if the level is still present.

Modes are written in two ways. A per-pin write sets the mode and channel of one pin. Two global write strobes share one data word, whose low 16 bits are a pin mask and whose bits 19:16 are the mode. One strobe covers pins 0 to 15 and the other covers pins 16 to 31, and a global write leaves the channel bits alone.

Top module: `gpio_event_detect`

## Requirements
- R1: After a synchronous active-low reset, all flags, both interrupt lines, both DMA request lines and both trigger lines are 0, and every pin is in mode 0 on channel 0.
- R2: Modes 5, 6 and 7 set the pin's flag on a rising, falling or either edge, and raise neither an interrupt nor a DMA request. The flag appears after the third rising clock edge following the pin change (two synchroniser stages plus detection), and not after the second.
- R3: Modes 1, 2 and 3 set the flag on a rising, falling or either edge and assert dma_req_o[c], where c is the pin's channel bit. A pulse on dma_done_i[c] clears such flags routed to c in the next cycle. A done pulse on the other channel has no effect.
- R4: A flag stays set until a clear write with a 1 in that pin's mask bit. When the channel filter is enabled, only pins whose channel bit equals the selected channel are cleared.
- R5: Modes 9, 10 and 11 set the flag on a rising, falling or either edge. irq_o[c] is the OR of the set flags in modes 8 to 12 whose channel bit is c.
- R6: Mode 8 sets the flag while the synchronised pin is 0, and mode 12 while it is 1. A software clear issued while that level persists leaves the flag set.
- R7: Mode 13 drives trg_o[c] with the synchronised pin level, and mode 14 with its inverse, two clock edges after the pin change. Neither mode sets a flag.
- R8: Modes 0, 4 and 15 never set a flag, whatever the pin does.
- R9: If a flag-setting event and a clear of the same pin fall in the same cycle, the flag ends up set.
- R10: A global write assigns the mode held in data bits 19:16 to every pin whose mask bit (data bits 15:0) is 1. The low strobe maps mask bit k to pin k, and the high strobe maps it to pin k+16. Pins outside the mask keep their mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | 32 | Asynchronous pin levels |
| cfg_we | input | 1 | Per-pin configuration write strobe |
| cfg_idx | input | 5 | Pin number for the per-pin write |
| cfg_mode | input | 4 | Mode for the per-pin write |
| cfg_chan | input | 1 | Channel bit for the per-pin write |
| gcfg_lo_we | input | 1 | Global write to pins 0 to 15 |
| gcfg_hi_we | input | 1 | Global write to pins 16 to 31 |
| gcfg_data | input | 20 | Global write word: mask in 15:0, mode in 19:16 |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 32 | One bit per pin to clear |
| clr_ch_en | input | 1 | Restrict the clear to one channel |
| clr_ch | input | 1 | Channel for a restricted clear |
| dma_done_i | input | 2 | Per-channel transfer-complete pulse |
| status_o | output | 32 | All flags, bit k for pin k |
| st_ch0_o | output | 32 | Flags of pins routed to channel 0 |
| st_ch1_o | output | 32 | Flags of pins routed to channel 1 |
| dma_flags_o | output | 32 | Flags of pins in DMA modes |
| irq_o | output | 2 | Interrupt line per channel |
| dma_req_o | output | 2 | DMA request per channel |
| trg_o | output | 2 | Trigger output per channel |

## Verification
On every cycle, the assertions check the flag lifetime rules. A disabled mode never sets a flag, a set flag persists until it is cleared, a set beats a clear, and a done pulse drops a DMA-mode flag. They also check that a global write lands in the pin's mode and that an active interrupt or DMA line has a matching flag behind it. The bench scenarios cover the behaviour that needs a chosen stimulus history. This includes the exact three-edge flag latency and the two-edge trigger latency, and the difference between rising, falling and either-edge modes. It also includes channel-filtered clears, the wrong-channel done pulse, level re-setting after a clear, and the half-port mapping of global writes.

// File: rtl/gpio_evt_pkg.sv
// Shared mode encoding and mode classification helpers for the pin event detector.
// Assumes a 4-bit mode per pin; values 4 and 15 are reserved and act as disabled.
package gpio_evt_pkg;

    localparam int MODE_W = 4;
    localparam int NUM_CH = 2;

    typedef logic [MODE_W-1:0] evt_mode_t;

    localparam evt_mode_t M_OFF      = 4'd0;
    localparam evt_mode_t M_DMA_RISE = 4'd1;
    localparam evt_mode_t M_DMA_FALL = 4'd2;
    localparam evt_mode_t M_DMA_BOTH = 4'd3;
    localparam evt_mode_t M_FLG_RISE = 4'd5;
    localparam evt_mode_t M_FLG_FALL = 4'd6;
    localparam evt_mode_t M_FLG_BOTH = 4'd7;
    localparam evt_mode_t M_IRQ_LOW  = 4'd8;
    localparam evt_mode_t M_IRQ_RISE = 4'd9;
    localparam evt_mode_t M_IRQ_FALL = 4'd10;
    localparam evt_mode_t M_IRQ_BOTH = 4'd11;
    localparam evt_mode_t M_IRQ_HIGH = 4'd12;
    localparam evt_mode_t M_TRG_HIGH = 4'd13;
    localparam evt_mode_t M_TRG_LOW  = 4'd14;

    // Mode requests a DMA transfer when its flag is set.
    function automatic logic mode_is_dma(evt_mode_t m);
        return (m == M_DMA_RISE) || (m == M_DMA_FALL) || (m == M_DMA_BOTH);
    endfunction

    // Mode raises an interrupt when its flag is set.
    function automatic logic mode_is_irq(evt_mode_t m);
        return (m >= M_IRQ_LOW) && (m <= M_IRQ_HIGH);
    endfunction

    // Mode reacts to a rising edge.
    function automatic logic mode_on_rise(evt_mode_t m);
        return (m == M_DMA_RISE) || (m == M_DMA_BOTH) || (m == M_FLG_RISE) ||
               (m == M_FLG_BOTH) || (m == M_IRQ_RISE) || (m == M_IRQ_BOTH);
    endfunction

    // Mode reacts to a falling edge.
    function automatic logic mode_on_fall(evt_mode_t m);
        return (m == M_DMA_FALL) || (m == M_DMA_BOTH) || (m == M_FLG_FALL) ||
               (m == M_FLG_BOTH) || (m == M_IRQ_FALL) || (m == M_IRQ_BOTH);
    endfunction

    // Mode can set a flag at all.
    function automatic logic mode_sets_flag(evt_mode_t m);
        return mode_on_rise(m) || mode_on_fall(m) || (m == M_IRQ_LOW) || (m == M_IRQ_HIGH);
    endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
// Two-flop synchroniser for a bus of pins plus one extra sample stage,
// so that edge detection compares consecutive synchronised levels.
// Assumes each pin is independent; no bus coherence is provided.
module gpio_evt_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prv_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] prv_q;

    // Shift the raw levels through two stages and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prv_q  <= '0;
        end else begin
            meta_q <= raw_i;
            lvl_q  <= meta_q;
            prv_q  <= lvl_q;
        end
    end

    assign lvl_o = lvl_q;
    assign prv_o = prv_q;

endmodule

// File: rtl/gpio_evt_cfg.sv
// Per-pin mode and channel storage. Global writes set the mode of masked pins
// in one half of the port; a per-pin write in the same cycle wins for its pin.
// Assumes NUM_PINS is even; the global mask covers NUM_PINS/2 pins.
module gpio_evt_cfg
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 32,
    localparam int HALF    = NUM_PINS / 2,
    localparam int IDX_W   = $clog2(NUM_PINS),
    localparam int GW      = HALF + MODE_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pin_we,
    input  logic [IDX_W-1:0]               pin_idx,
    input  evt_mode_t                      pin_mode,
    input  logic                           pin_chan,
    input  logic                           glo_we,
    input  logic                           ghi_we,
    input  logic [GW-1:0]                  g_data,
    output logic [NUM_PINS-1:0][MODE_W-1:0] mode_o,
    output logic [NUM_PINS-1:0]            chan_o
);

    evt_mode_t g_mode;
    assign g_mode = g_data[HALF +: MODE_W];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int  MB    = p % HALF;
        localparam bit  IS_HI = (p >= HALF);

        logic g_hit;
        logic p_hit;
        assign g_hit = (IS_HI ? ghi_we : glo_we) & g_data[MB];
        assign p_hit = pin_we && (pin_idx == IDX_W'(p));

        // Store this pin's mode and channel; per-pin write overrides global.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_o[p] <= M_OFF;
                chan_o[p] <= 1'b0;
            end else if (p_hit) begin
                mode_o[p] <= pin_mode;
                chan_o[p] <= pin_chan;
            end else if (g_hit) begin
                mode_o[p] <= g_mode;
            end
        end
    end

    // R10
    glo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glo_we && g_data[0] && !(pin_we && pin_idx == '0))
        |=> mode_o[0] == $past(g_data[HALF +: MODE_W]));

    // R10
    ghi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ghi_we && g_data[0] && !(pin_we && pin_idx == IDX_W'(HALF)))
        |=> mode_o[HALF] == $past(g_data[HALF +: MODE_W]));

endmodule

// File: rtl/gpio_evt_pin.sv
// Event detection for one pin: decodes its mode against the synchronised level
// and the previous level, keeps the sticky flag, and forms the trigger level.
// Assumes clr_i and done_i are already qualified by this pin's channel.
module gpio_evt_pin
    import gpio_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl_i,
    input  logic      prv_i,
    input  evt_mode_t mode_i,
    input  logic      clr_i,
    input  logic      done_i,
    output logic      flag_o,
    output logic      trg_o
);

    logic rise, fall, hit, flag_q, drop;

    // Decide whether this cycle's samples form an event for the current mode.
    always_comb begin
        rise = lvl_i & ~prv_i;
        fall = ~lvl_i & prv_i;
        hit  = (mode_on_rise(mode_i) & rise) |
               (mode_on_fall(mode_i) & fall) |
               ((mode_i == M_IRQ_LOW)  & ~lvl_i) |
               ((mode_i == M_IRQ_HIGH) &  lvl_i);
        drop = clr_i | (mode_is_dma(mode_i) & done_i);
    end

    // Sticky flag: an event sets it and beats any clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= hit | (flag_q & ~drop);
    end

    // Trigger modes pass the synchronised level straight through.
    always_comb begin
        unique case (mode_i)
            M_TRG_HIGH: trg_o = lvl_i;
            M_TRG_LOW:  trg_o = ~lvl_i;
            default:    trg_o = 1'b0;
        endcase
    end

    assign flag_o = flag_q;

    // R8
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !mode_sets_flag(mode_i)) |=> !flag_q);

    // R9
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr_i) |=> flag_q);

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i && !done_i) |=> flag_q);

    // R3
    dma_done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && mode_is_dma(mode_i) && done_i && !hit) |=> !flag_q);

endmodule

// File: rtl/gpio_event_detect.sv
// Top of the pin event detector: synchronises the pins, holds per-pin
// configuration, runs one detector per pin and merges flags into the
// per-channel interrupt, DMA request and trigger outputs.
// Assumes dma_done_i is a one-cycle pulse per completed transfer.
module gpio_event_detect
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 32,
    localparam int HALF    = NUM_PINS / 2,
    localparam int IDX_W   = $clog2(NUM_PINS),
    localparam int GW      = HALF + MODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [MODE_W-1:0]   cfg_mode,
    input  logic                cfg_chan,
    input  logic                gcfg_lo_we,
    input  logic                gcfg_hi_we,
    input  logic [GW-1:0]       gcfg_data,
    input  logic                clr_we,
    input  logic [NUM_PINS-1:0] clr_mask,
    input  logic                clr_ch_en,
    input  logic                clr_ch,
    input  logic [NUM_CH-1:0]   dma_done_i,
    output logic [NUM_PINS-1:0] status_o,
    output logic [NUM_PINS-1:0] st_ch0_o,
    output logic [NUM_PINS-1:0] st_ch1_o,
    output logic [NUM_PINS-1:0] dma_flags_o,
    output logic [NUM_CH-1:0]   irq_o,
    output logic [NUM_CH-1:0]   dma_req_o,
    output logic [NUM_CH-1:0]   trg_o
);

    logic [NUM_PINS-1:0]             lvl, prv, chan, flag, trg, clr_bit, done_bit;
    logic [NUM_PINS-1:0][MODE_W-1:0] mode;

    gpio_evt_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(pin_i), .lvl_o(lvl), .prv_o(prv)
    );

    gpio_evt_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .pin_we(cfg_we), .pin_idx(cfg_idx), .pin_mode(cfg_mode), .pin_chan(cfg_chan),
        .glo_we(gcfg_lo_we), .ghi_we(gcfg_hi_we), .g_data(gcfg_data),
        .mode_o(mode), .chan_o(chan)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_det
        assign clr_bit[p]  = clr_we & clr_mask[p] & (~clr_ch_en | (chan[p] == clr_ch));
        assign done_bit[p] = dma_done_i[chan[p]];

        gpio_evt_pin u_pin (
            .clk(clk), .rst_n(rst_n),
            .lvl_i(lvl[p]), .prv_i(prv[p]), .mode_i(mode[p]),
            .clr_i(clr_bit[p]), .done_i(done_bit[p]),
            .flag_o(flag[p]), .trg_o(trg[p])
        );
    end

    // Merge per-pin flags and triggers into the channel outputs and views.
    always_comb begin
        irq_o       = '0;
        dma_req_o   = '0;
        trg_o       = '0;
        dma_flags_o = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            dma_flags_o[p] = flag[p] & mode_is_dma(mode[p]);
            if (flag[p] && mode_is_irq(mode[p])) irq_o[chan[p]] = 1'b1;
            if (dma_flags_o[p])                  dma_req_o[chan[p]] = 1'b1;
            if (trg[p])                          trg_o[chan[p]] = 1'b1;
        end
    end

    assign status_o = flag;
    assign st_ch0_o = flag & ~chan;
    assign st_ch1_o = flag & chan;

    // R5
    irq0_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[0] |-> (st_ch0_o != '0));

    // R3
    dma1_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o[1] |-> ((dma_flags_o & st_ch1_o) != '0));

endmodule

// File: tb/gpio_event_detect_tb_top.sv
module gpio_event_detect_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pin_i;
    logic        cfg_we;
    logic [4:0]  cfg_idx;
    logic [3:0]  cfg_mode;
    logic        cfg_chan;
    logic        gcfg_lo_we, gcfg_hi_we;
    logic [19:0] gcfg_data;
    logic        clr_we;
    logic [31:0] clr_mask;
    logic        clr_ch_en, clr_ch;
    logic [1:0]  dma_done_i;
    logic [31:0] status_o, st_ch0_o, st_ch1_o, dma_flags_o;
    logic [1:0]  irq_o, dma_req_o, trg_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_event_detect dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mode(cfg_mode), .cfg_chan(cfg_chan),
        .gcfg_lo_we(gcfg_lo_we), .gcfg_hi_we(gcfg_hi_we), .gcfg_data(gcfg_data),
        .clr_we(clr_we), .clr_mask(clr_mask), .clr_ch_en(clr_ch_en), .clr_ch(clr_ch),
        .dma_done_i(dma_done_i),
        .status_o(status_o), .st_ch0_o(st_ch0_o), .st_ch1_o(st_ch1_o),
        .dma_flags_o(dma_flags_o), .irq_o(irq_o), .dma_req_o(dma_req_o), .trg_o(trg_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(input int p, input logic [3:0] m, input logic c);
        cfg_we = 1'b1; cfg_idx = 5'(p); cfg_mode = m; cfg_chan = c;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic clear(input logic [31:0] mask, input logic en, input logic ch);
        clr_we = 1'b1; clr_mask = mask; clr_ch_en = en; clr_ch = ch;
        tick(1);
        clr_we = 1'b0; clr_ch_en = 1'b0;
    endtask

    task automatic cleanup();
        pin_i = '0;
        tick(3);
        gcfg_data = {4'd0, 16'hFFFF}; gcfg_lo_we = 1'b1; gcfg_hi_we = 1'b1;
        tick(1);
        gcfg_lo_we = 1'b0; gcfg_hi_we = 1'b0;
        clear('1, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 status", status_o, 32'h0);
        chk("R1 outputs", {26'd0, irq_o, dma_req_o, trg_o}, 32'h0);
    endtask

    task automatic t_flag_only();
        set_mode(0, 4'd5, 1'b0);
        pin_i[0] = 1'b1;
        tick(2);
        chk("R2 latency not yet", status_o, 32'h0);
        tick(1);
        chk("R2 rise flag", status_o, 32'h1);
        chk("R2 no irq/dma", {30'd0, irq_o | dma_req_o}, 32'h0);
        pin_i[1] = 1'b1;
        tick(3);
        set_mode(1, 4'd6, 1'b0);
        pin_i[1] = 1'b0;
        pin_i[0] = 1'b0;
        tick(3);
        chk("R2 fall flag, mode5 ignores fall", status_o, 32'h3);
        clear(32'h3, 1'b0, 1'b0);
        chk("R4 clear", status_o, 32'h0);
        cleanup();
    endtask

    task automatic t_dma();
        set_mode(2, 4'd1, 1'b1);
        pin_i[2] = 1'b1;
        tick(3);
        chk("R3 flag", status_o, 32'h4);
        chk("R3 req ch1", {30'd0, dma_req_o}, 32'h2);
        chk("R3 dma view", dma_flags_o, 32'h4);
        dma_done_i = 2'b01;
        tick(1);
        dma_done_i = 2'b00;
        chk("R3 wrong done ignored", status_o, 32'h4);
        dma_done_i = 2'b10;
        tick(1);
        dma_done_i = 2'b00;
        chk("R3 done clears", status_o, 32'h0);
        chk("R3 req drops", {30'd0, dma_req_o}, 32'h0);
        cleanup();
    endtask

    task automatic t_irq();
        set_mode(3, 4'd11, 1'b0);
        set_mode(4, 4'd9, 1'b1);
        pin_i[3] = 1'b1;
        tick(3);
        chk("R5 irq0 on rise", {30'd0, irq_o}, 32'h1);
        clear(32'h8, 1'b0, 1'b0);
        chk("R5 irq0 low after clear", {30'd0, irq_o}, 32'h0);
        pin_i[3] = 1'b0;
        tick(3);
        chk("R5 irq0 on fall", {30'd0, irq_o}, 32'h1);
        pin_i[4] = 1'b1;
        tick(3);
        chk("R5 both lines", {30'd0, irq_o}, 32'h3);
        chk("R5 ch1 view", st_ch1_o, 32'h10);
        chk("R5 ch0 view", st_ch0_o, 32'h08);
        clear('1, 1'b1, 1'b1);
        chk("R4 channel clear", status_o, 32'h08);
        chk("R4 channel clear irq", {30'd0, irq_o}, 32'h1);
        clear('1, 1'b0, 1'b0);
        pin_i[4] = 1'b0;
        tick(3);
        chk("R5 mode9 ignores fall", status_o, 32'h0);
        cleanup();
    endtask

    task automatic t_level();
        pin_i[5] = 1'b1;
        tick(3);
        set_mode(5, 4'd12, 1'b0);
        tick(1);
        chk("R6 high level flag", status_o, 32'h20);
        chk("R6 high level irq", {30'd0, irq_o}, 32'h1);
        clear(32'h20, 1'b0, 1'b0);
        chk("R6 resets while high", status_o, 32'h20);
        pin_i[5] = 1'b0;
        tick(3);
        clear(32'h20, 1'b0, 1'b0);
        chk("R6 clears once low", status_o, 32'h0);
        set_mode(5, 4'd8, 1'b0);
        tick(1);
        chk("R6 low level flag", status_o, 32'h20);
        cleanup();
    endtask

    task automatic t_trigger();
        set_mode(6, 4'd13, 1'b1);
        chk("R7 trig idle", {30'd0, trg_o}, 32'h0);
        pin_i[6] = 1'b1;
        tick(1);
        chk("R7 trig not yet", {30'd0, trg_o}, 32'h0);
        tick(1);
        chk("R7 trig high", {30'd0, trg_o}, 32'h2);
        set_mode(7, 4'd14, 1'b0);
        chk("R7 inverted trig", {30'd0, trg_o}, 32'h3);
        pin_i[7] = 1'b1;
        tick(2);
        chk("R7 inverted follows", {30'd0, trg_o}, 32'h2);
        chk("R7 no flag", status_o, 32'h0);
        cleanup();
    endtask

    task automatic t_disabled();
        set_mode(9, 4'd4, 1'b0);
        set_mode(10, 4'd15, 1'b1);
        pin_i[10:8] = 3'b111;
        tick(3);
        chk("R8 no flag on rise", status_o, 32'h0);
        pin_i[10:8] = 3'b000;
        tick(3);
        chk("R8 no flag on fall", status_o, 32'h0);
        cleanup();
    endtask

    task automatic t_set_wins();
        set_mode(12, 4'd5, 1'b0);
        pin_i[12] = 1'b1;
        tick(2);
        clear(32'h1000, 1'b0, 1'b0);
        chk("R9 set beats clear", status_o, 32'h1000);
        clear(32'h1000, 1'b0, 1'b0);
        chk("R4 later clear", status_o, 32'h0);
        cleanup();
    endtask

    task automatic t_global();
        gcfg_data = {4'd5, 16'h0005}; gcfg_lo_we = 1'b1;
        tick(1);
        gcfg_lo_we = 1'b0;
        gcfg_data = {4'd7, 16'h0001}; gcfg_hi_we = 1'b1;
        tick(1);
        gcfg_hi_we = 1'b0;
        pin_i = 32'h0003_0007;
        tick(3);
        chk("R10 masked pins only", status_o, 32'h0001_0005);
        clear('1, 1'b0, 1'b0);
        pin_i = '0;
        tick(3);
        chk("R10 hi mode7 falls", status_o, 32'h0001_0000);
        cleanup();
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pin_i = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_mode = '0; cfg_chan = 1'b0;
        gcfg_lo_we = 1'b0; gcfg_hi_we = 1'b0; gcfg_data = '0;
        clr_we = 1'b0; clr_mask = '0; clr_ch_en = 1'b0; clr_ch = 1'b0; dma_done_i = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_flag_only();
        t_dma();
        t_irq();
        t_level();
        t_trigger();
        t_disabled();
        t_set_wins();
        t_global();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule